// File: doc/BRIEF.md
# Half-Duplex Serial Bit Shifter

This block moves bytes over one shared bidirectional serial data line. It generates the serial clock, drives the data pin when sending, and samples the same line when receiving. Sending and receiving are separate modes with separate bit timings. Transmit runs at one third of the system clock. Receive runs at one fifth, which leaves time for the slower edges of the returning data. Between transfers the data pin is released, so other logic can use the line as an interrupt input.

The host selects a mode, then either feeds bytes into the transmit queue or asks for a number of bytes to be received. It watches the `done` flag to learn when the line has gone fully quiet. In write mode that is when the queue is empty and the final bit has left the shifter. In read mode it is when the requested byte count has been collected into the receive queue.

Top module: `hds_shifter`

## Requirements
- R1: In write mode each byte taken from the transmit queue leaves on `sdo` most-significant bit first, in queue order.
- R2: A transmitted bit spans 3 system clocks: `sclk` low, low, high. `sdo` holds the new bit from the second low clock through the high clock.
- R3: A received bit spans 5 system clocks: `sclk` high for 3, then low for 2. `sdi` is captured at the clock edge that ends the first low clock, and bits assemble most-significant first.
- R4: A `rd_start` pulse with `rd_count` = N-1, taken in read mode while `done` is high, receives exactly N bytes. Each completed byte goes into the receive queue, and `done` returns high after the last one.
- R5: `done` is high exactly when the transmit queue is empty and neither shifter is part-way through a byte. In write mode it rises only after the high clock of the final bit.
- R6: `sclk` is low whenever no bit is in progress: after reset, between bursts and after a transfer.
- R7: `sdo_oe` is high exactly while the mode is write (`mode_sel` = 0). The mode after reset is read (`mode_sel` = 1), so the pin starts released.
- R8: Both queues hold FIFO_DEPTH bytes and report full and empty. A push into a full queue is discarded, and a pop from an empty queue does nothing.
- R9: `mode_load` takes effect only while `done` is high. It then loads the mode from `mode_sel` and empties both queues. At any other time it is ignored.
- R10: `tx_push` is ignored in read mode. `rd_start` is ignored in write mode and while `done` is low.
- R11: After reset: `sclk` = 0, `sdo_oe` = 0, `done` = 1, both queues empty.
- R12: If another byte is queued when a transmitted byte ends, its first bit starts at once. The `sclk` period stays 3 clocks across byte boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Requested mode: 0 write, 1 read |
| mode_load | input | 1 | Apply `mode_sel` (honoured only while done) |
| tx_data | input | 8 | Byte to enqueue for transmit |
| tx_push | input | 1 | Enqueue `tx_data` |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_data | output | 8 | Oldest received byte |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rd_count | input | CNT_W | Bytes to receive, minus one |
| rd_start | input | 1 | Begin a receive of `rd_count`+1 bytes |
| done | output | 1 | Line idle, nothing pending |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data pin |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and CNT_W = 8. With a four-entry receive queue, a single six-byte receive with no pops is enough to fill the queue and show bytes being discarded. Transmit bursts of three bytes pushed back to back cross byte boundaries without a gap, which exposes the 3-clock period at the seams. A behavioural model of both bit timings is compared against the pins on every clock, through mode changes that are refused while busy and accepted once the line is idle.

// File: rtl/hds_pkg.sv
package hds_pkg;

    typedef enum logic {
        MODE_WRITE = 1'b0,
        MODE_READ  = 1'b1
    } hds_mode_e;

    localparam int unsigned BYTE_BITS      = 8;
    localparam int unsigned TX_BIT_CYCLES  = 3;
    localparam int unsigned RX_BIT_CYCLES  = 5;
    localparam int unsigned RX_HIGH_CYCLES = 3;
    localparam int unsigned PHASE_W        = 3;
    localparam int unsigned BITN_W         = $clog2(BYTE_BITS);

    typedef logic [BYTE_BITS-1:0] byte_t;

    typedef struct packed {
        logic               busy;
        logic [PHASE_W-1:0] phase;
        logic [BITN_W-1:0]  bitn;
        byte_t              shreg;
    } shift_state_t;

    localparam shift_state_t SHIFT_IDLE = '{busy: 1'b0, phase: '0, bitn: '0, shreg: '0};

    function automatic logic is_last_bit(input logic [BITN_W-1:0] b);
        return b == BITN_W'(BYTE_BITS - 1);
    endfunction

endpackage

// File: rtl/hds_fifo.sv
module hds_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/hds_tx_engine.sv
module hds_tx_engine
    import hds_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  fifo_empty,
    input  byte_t fifo_data,
    output logic  fifo_pop,
    output logic  sclk_hi,
    output logic  sdo,
    output logic  busy
);
    localparam logic [PHASE_W-1:0] PH_HIGH = PHASE_W'(TX_BIT_CYCLES - 1);

    shift_state_t st, st_n;
    logic         sdo_q, sdo_n;

    always_comb begin
        st_n     = st;
        sdo_n    = sdo_q;
        fifo_pop = 1'b0;
        if (!st.busy) begin
            if (enable && !fifo_empty) begin
                fifo_pop    = 1'b1;
                st_n.busy   = 1'b1;
                st_n.phase  = '0;
                st_n.bitn   = '0;
                st_n.shreg  = fifo_data;
            end
        end else if (st.phase == '0) begin
            sdo_n      = st.shreg[BYTE_BITS-1];
            st_n.phase = st.phase + PHASE_W'(1);
        end else if (st.phase == PH_HIGH) begin
            st_n.phase = '0;
            st_n.shreg = {st.shreg[BYTE_BITS-2:0], 1'b0};
            st_n.bitn  = st.bitn + BITN_W'(1);
            if (is_last_bit(st.bitn)) begin
                st_n.bitn = '0;
                if (!fifo_empty) begin
                    fifo_pop   = 1'b1;
                    st_n.shreg = fifo_data;
                end else begin
                    st_n.busy = 1'b0;
                end
            end
        end else begin
            st_n.phase = st.phase + PHASE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SHIFT_IDLE;
            sdo_q <= 1'b0;
        end else begin
            st    <= st_n;
            sdo_q <= sdo_n;
        end
    end

    assign sclk_hi = st.busy && (st.phase == PH_HIGH);
    assign sdo     = sdo_q;
    assign busy    = st.busy;

endmodule

// File: rtl/hds_rx_engine.sv
module hds_rx_engine
    import hds_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             sdi,
    output logic             push,
    output byte_t            push_data,
    output logic             sclk_hi,
    output logic             busy
);
    localparam logic [PHASE_W-1:0] PH_SAMPLE = PHASE_W'(RX_HIGH_CYCLES);
    localparam logic [PHASE_W-1:0] PH_END    = PHASE_W'(RX_BIT_CYCLES - 1);

    shift_state_t     st, st_n;
    logic [CNT_W-1:0] left, left_n;

    always_comb begin
        st_n      = st;
        left_n    = left;
        push      = 1'b0;
        push_data = {st.shreg[BYTE_BITS-2:0], sdi};
        if (!st.busy) begin
            if (start) begin
                st_n.busy  = 1'b1;
                st_n.phase = '0;
                st_n.bitn  = '0;
                left_n     = count;
            end
        end else if (st.phase == PH_SAMPLE) begin
            st_n.shreg = {st.shreg[BYTE_BITS-2:0], sdi};
            st_n.phase = st.phase + PHASE_W'(1);
            push       = is_last_bit(st.bitn);
        end else if (st.phase == PH_END) begin
            st_n.phase = '0;
            if (is_last_bit(st.bitn)) begin
                st_n.bitn = '0;
                if (left == '0) begin
                    st_n.busy = 1'b0;
                end else begin
                    left_n = left - CNT_W'(1);
                end
            end else begin
                st_n.bitn = st.bitn + BITN_W'(1);
            end
        end else begin
            st_n.phase = st.phase + PHASE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SHIFT_IDLE;
            left <= '0;
        end else begin
            st   <= st_n;
            left <= left_n;
        end
    end

    assign sclk_hi = st.busy && (st.phase < PH_SAMPLE);
    assign busy    = st.busy;

endmodule

// File: rtl/hds_shifter.sv
module hds_shifter
    import hds_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_sel,
    input  logic             mode_load,
    input  logic [7:0]       tx_data,
    input  logic             tx_push,
    output logic             tx_full,
    output logic             tx_empty,
    output logic [7:0]       rx_data,
    input  logic             rx_pop,
    output logic             rx_full,
    output logic             rx_empty,
    input  logic [CNT_W-1:0] rd_count,
    input  logic             rd_start,
    output logic             done,
    output logic             sclk,
    output logic             sdo,
    output logic             sdo_oe,
    input  logic             sdi
);
    hds_mode_e mode;
    logic      mode_take;
    logic      tx_busy, rx_busy;
    logic      tx_pop, tx_sclk, rx_sclk;
    logic      rx_push, rx_go;
    byte_t     tx_head, rx_byte;

    assign done      = !tx_busy && !rx_busy && tx_empty;
    assign mode_take = mode_load && done;
    assign rx_go     = rd_start && done && (mode == MODE_READ) && !mode_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_READ;
        end else if (mode_take) begin
            mode <= hds_mode_e'(mode_sel);
        end
    end

    hds_fifo #(.W(BYTE_BITS), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (mode_take),
        .push  (tx_push && (mode == MODE_WRITE)),
        .wdata (tx_data),
        .pop   (tx_pop),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    hds_fifo #(.W(BYTE_BITS), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (mode_take),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (rx_pop),
        .rdata (rx_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    hds_tx_engine u_tx (
        .clk        (clk),
        .rst        (rst),
        .enable     (mode == MODE_WRITE),
        .fifo_empty (tx_empty),
        .fifo_data  (tx_head),
        .fifo_pop   (tx_pop),
        .sclk_hi    (tx_sclk),
        .sdo        (sdo),
        .busy       (tx_busy)
    );

    hds_rx_engine #(.CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .start     (rx_go),
        .count     (rd_count),
        .sdi       (sdi),
        .push      (rx_push),
        .push_data (rx_byte),
        .sclk_hi   (rx_sclk),
        .busy      (rx_busy)
    );

    assign sclk   = tx_sclk | rx_sclk;
    assign sdo_oe = (mode == MODE_WRITE);

endmodule

// File: rtl/hds_shifter_chk.sv
module hds_shifter_chk (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic sdo,
    input logic sdo_oe,
    input logic done
);
    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        done |-> !sclk); // R6

    AST_TX_HIGH_ONE: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && sclk) |=> !sclk); // R2

    AST_TX_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && sclk) |-> $stable(sdo)); // R2

    AST_RX_HIGH_THREE: assert property (@(posedge clk) disable iff (rst)
        (!sdo_oe && $rose(sclk)) |=> sclk ##1 sclk ##1 !sclk); // R3

    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(sdo_oe)); // R9

endmodule

bind hds_shifter hds_shifter_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .sclk   (sclk),
    .sdo    (sdo),
    .sdo_oe (sdo_oe),
    .done   (done)
);

// File: tb/hds_shifter_tb.sv
module hds_shifter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sel = 1'b1, mode_load = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_push = 1'b0;
    logic       tx_full, tx_empty;
    logic [7:0] rx_data;
    logic       rx_pop = 1'b0;
    logic       rx_full, rx_empty;
    logic [7:0] rd_count = '0;
    logic       rd_start = 1'b0;
    logic       done, sclk, sdo, sdo_oe;
    logic       sdi = 1'b0;

    always #4 clk = ~clk;

    hds_shifter #(.FIFO_DEPTH(4), .CNT_W(8)) u_dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .mode_load(mode_load),
        .tx_data(tx_data), .tx_push(tx_push), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_data(rx_data), .rx_pop(rx_pop), .rx_full(rx_full), .rx_empty(rx_empty),
        .rd_count(rd_count), .rd_start(rd_start), .done(done),
        .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
    );

    int checks = 0, failures = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit           m_mode;
    byte unsigned m_txq[$];
    byte unsigned m_rxq[$];
    bit           m_tx_act;  int m_tx_ph, m_tx_bit; byte unsigned m_tx_byte; bit m_sdo;
    bit           m_rx_act;  int m_rx_ph, m_rx_bit, m_rx_left; byte unsigned m_rx_sh;
    bit           m_take, m_start, m_txfull_o, m_rxfull_o, m_rxhad, m_rxpush;

    function automatic bit m_done();
        return !m_tx_act && !m_rx_act && (m_txq.size() == 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 1'b1; m_txq.delete(); m_rxq.delete();
            m_tx_act = 0; m_tx_ph = 0; m_tx_bit = 0; m_sdo = 0;
            m_rx_act = 0; m_rx_ph = 0; m_rx_bit = 0; m_rx_left = 0; m_rx_sh = 0;
        end else begin
            m_take     = mode_load && m_done();
            m_start    = rd_start && m_done() && m_mode && !m_take;
            m_txfull_o = m_txq.size() >= 4;
            m_rxfull_o = m_rxq.size() >= 4;
            m_rxhad    = m_rxq.size() > 0;
            m_rxpush   = 0;
            if (m_tx_act) begin
                if (m_tx_ph == 0) begin m_sdo = m_tx_byte[7 - m_tx_bit]; m_tx_ph = 1; end
                else if (m_tx_ph == 1) m_tx_ph = 2;
                else begin
                    m_tx_ph = 0; m_tx_bit++;
                    if (m_tx_bit == 8) begin
                        m_tx_bit = 0;
                        if (m_txq.size() > 0) m_tx_byte = m_txq.pop_front();
                        else m_tx_act = 0;
                    end
                end
            end else if (!m_mode && m_txq.size() > 0) begin
                m_tx_byte = m_txq.pop_front(); m_tx_act = 1; m_tx_ph = 0; m_tx_bit = 0;
            end
            if (m_rx_act) begin
                if (m_rx_ph == 3) begin
                    m_rx_sh = {m_rx_sh[6:0], sdi};
                    m_rxpush = (m_rx_bit == 7);
                    m_rx_ph = 4;
                end else if (m_rx_ph == 4) begin
                    m_rx_ph = 0;
                    if (m_rx_bit == 7) begin
                        m_rx_bit = 0;
                        if (m_rx_left == 0) m_rx_act = 0; else m_rx_left--;
                    end else m_rx_bit++;
                end else m_rx_ph++;
            end else if (m_start) begin
                m_rx_act = 1; m_rx_ph = 0; m_rx_bit = 0; m_rx_left = rd_count;
            end
            if (rx_pop && m_rxhad) void'(m_rxq.pop_front());
            if (m_rxpush && !m_rxfull_o) m_rxq.push_back(m_rx_sh);
            if (tx_push && !m_mode && !m_txfull_o) m_txq.push_back(tx_data);
            if (m_take) begin
                m_txq.delete(); m_rxq.delete(); m_mode = mode_sel;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    bit e_sclk;
    always @(negedge clk) begin
        if (!rst) begin
            e_sclk = (m_tx_act && m_tx_ph == 2) || (m_rx_act && m_rx_ph < 3);
            chk(sclk == e_sclk, "R2 R3 R6", "sclk vs model", sclk, e_sclk);
            chk(sdo_oe == !m_mode, "R7", "sdo_oe vs model", sdo_oe, !m_mode);
            chk(done == m_done(), "R5", "done vs model", done, m_done());
            chk(tx_empty == (m_txq.size() == 0) && tx_full == (m_txq.size() == 4),
                "R8", "tx flags vs model", {tx_full, tx_empty}, m_txq.size());
            chk(rx_empty == (m_rxq.size() == 0) && rx_full == (m_rxq.size() == 4),
                "R8", "rx flags vs model", {rx_full, rx_empty}, m_rxq.size());
            if (e_sclk && !m_mode)
                chk(sdo == m_sdo, "R1", "sdo during high", sdo, m_sdo);
            if (m_rxq.size() > 0)
                chk(rx_data == m_rxq[0], "R4", "rx head vs model", rx_data, m_rxq[0]);
        end
    end

    // ---------------- serial partner and line observers ----------------
    byte unsigned dev_q[$];
    int           dev_bit = 0;
    bit           prev_sclk = 0;
    int           cyc = 0, last_rise = -1, per_min = 1000, per_max = 0;
    byte unsigned cap_q[$];
    byte unsigned cap_sh = 0;
    int           cap_n = 0;

    always @(negedge clk) begin
        cyc++;
        if (sclk && !prev_sclk) begin
            if (last_rise >= 0) begin
                if (cyc - last_rise < per_min) per_min = cyc - last_rise;
                if (cyc - last_rise > per_max) per_max = cyc - last_rise;
            end
            last_rise = cyc;
            if (!sdo_oe) begin
                if (dev_q.size() > 0) begin
                    sdi = dev_q[0][7 - dev_bit];
                    dev_bit++;
                    if (dev_bit == 8) begin dev_bit = 0; void'(dev_q.pop_front()); end
                end else sdi = 1'b0;
            end else begin
                cap_sh = {cap_sh[6:0], sdo};
                cap_n++;
                if (cap_n == 8) begin cap_q.push_back(cap_sh); cap_n = 0; end
            end
        end
        prev_sclk = sclk;
    end

    task automatic clr_period();
        last_rise = -1; per_min = 1000; per_max = 0;
    endtask

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic set_mode(input bit m);
        mode_sel = m; mode_load = 1'b1; @(negedge clk); mode_load = 1'b0;
    endtask

    task automatic wait_done();
        repeat (2) @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    task automatic start_read(input int n);
        rd_count = 8'(n - 1); rd_start = 1'b1; @(negedge clk); rd_start = 1'b0;
    endtask

    task automatic pop_rx(output byte unsigned b);
        b = rx_data; rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    endtask

    byte unsigned got;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(sclk == 0, "R11", "reset sclk", sclk, 0);
        chk(sdo_oe == 0, "R11", "reset sdo_oe", sdo_oe, 0);
        chk(done == 1, "R11", "reset done", done, 1);
        chk(tx_empty && rx_empty, "R11", "reset queues empty", {tx_empty, rx_empty}, 3);

        // R7 enter write mode
        set_mode(1'b0);
        chk(sdo_oe == 1, "R7", "oe in write mode", sdo_oe, 1);

        // R1 R2 R12 back-to-back burst
        clr_period();
        cap_q.delete();
        tx_push = 1'b1;
        tx_data = 8'hA5; @(negedge clk);
        tx_data = 8'h3C; @(negedge clk);
        tx_data = 8'hF0; @(negedge clk);
        tx_push = 1'b0;
        wait_done();
        chk(cap_q.size() == 3, "R1", "bytes on line", cap_q.size(), 3);
        if (cap_q.size() == 3) begin
            chk(cap_q[0] == 8'hA5, "R1", "byte0 msb first", cap_q[0], 8'hA5);
            chk(cap_q[1] == 8'h3C, "R1", "byte1 msb first", cap_q[1], 8'h3C);
            chk(cap_q[2] == 8'hF0, "R1", "byte2 msb first", cap_q[2], 8'hF0);
        end
        chk(per_min == 3 && per_max == 3, "R2 R12", "write sclk period", per_max, 3);
        chk(sclk == 0, "R6", "sclk low after burst", sclk, 0);

        // R9 mode change refused while busy
        tx_data = 8'h5E; tx_push = 1'b1; @(negedge clk); tx_push = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 0, "R5", "busy mid byte", done, 0);
        set_mode(1'b1);
        chk(sdo_oe == 1, "R9", "mode load ignored while busy", sdo_oe, 1);
        wait_done();

        // R10 tx push ignored in read mode
        set_mode(1'b1);
        chk(sdo_oe == 0, "R7", "oe released in read mode", sdo_oe, 0);
        tx_data = 8'h77; tx_push = 1'b1; @(negedge clk); tx_push = 1'b0;
        @(negedge clk);
        chk(tx_empty == 1 && done == 1, "R10", "tx push ignored in read", tx_empty, 1);

        // R3 R4 three byte read
        clr_period();
        dev_q = '{8'h81, 8'h7E, 8'hC3}; dev_bit = 0;
        start_read(3);
        wait_done();
        chk(per_min == 5 && per_max == 5, "R3", "read sclk period", per_max, 5);
        pop_rx(got); chk(got == 8'h81, "R3", "rx byte0", got, 8'h81);
        pop_rx(got); chk(got == 8'h7E, "R3", "rx byte1", got, 8'h7E);
        pop_rx(got); chk(got == 8'hC3, "R4", "rx byte2", got, 8'hC3);
        chk(rx_empty == 1, "R4", "exactly three bytes", rx_empty, 1);

        // R10 rd_start ignored while busy
        dev_q = '{8'h5A, 8'h11, 8'h22, 8'h33}; dev_bit = 0;
        start_read(1);
        rd_count = 8'd3; rd_start = 1'b1; @(negedge clk); rd_start = 1'b0;
        wait_done();
        pop_rx(got); chk(got == 8'h5A, "R10", "single byte read", got, 8'h5A);
        chk(rx_empty == 1, "R10", "second start ignored", rx_empty, 1);

        // R8 overflow of receive queue
        dev_q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06}; dev_bit = 0;
        start_read(6);
        wait_done();
        chk(rx_full == 1, "R8", "rx queue full", rx_full, 1);
        for (int i = 1; i <= 4; i++) begin
            pop_rx(got);
            chk(got == 8'(i), "R8", "kept oldest bytes", got, i);
        end
        chk(rx_empty == 1, "R8", "extra bytes discarded", rx_empty, 1);
        pop_rx(got);
        chk(rx_empty == 1 && rx_full == 0, "R8", "pop of empty harmless", rx_empty, 1);

        // R9 accepted mode change flushes receive queue
        dev_q = '{8'h99}; dev_bit = 0;
        start_read(1);
        wait_done();
        chk(rx_empty == 0, "R4", "byte waiting", rx_empty, 0);
        set_mode(1'b0);
        chk(rx_empty == 1, "R9", "flush on mode change", rx_empty, 1);
        chk(sdo_oe == 1, "R9", "mode applied when done", sdo_oe, 1);

        // R10 rd_start ignored in write mode
        start_read(1);
        @(negedge clk);
        chk(done == 1 && sclk == 0, "R10", "rd_start ignored in write", done, 1);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule